// File: doc/BRIEF.md
# Boot Strap Capture and Reset Dispatcher

This block sits at the reset entry of a device. It samples the boot-strap pin bus into a status register when a cold power-on reset ends. It then splits the captured word into fields: a boot device code, device-specific configuration, and a 3-bit clock select. The clock select field has two possible meanings, and the boot device code decides which one applies. Some serial-memory boot devices run with the clock generator bypassed. For those devices the top field is reported as extended configuration and not as a clock select.

The block accepts four reset requests: power-on, full, soft/hard and core-local. It remembers the strongest request seen while reset is active. When the last request drops, it issues exactly one action:
- a boot-start pulse,
- a resume-from-hibernation request that carries a branch address, or
- a core-only reset pulse.

The hibernation state is read only after a power-on or full reset. The clock generator, the boot code and the peripherals are outside this block.

Top module: `strap_reset_dispatch`

## Requirements
- R1: While the power-on request is high, all status fields, the bypass flag and all three pulse outputs read zero.
- R2: When a reset window that contains a power-on request is released, the status holds the strap value: the boot device code is strap[2:0] and the device configuration is strap[9:3].
- R3: When the captured boot device code is 5 or 6, the bypass flag is 1, the extended configuration is strap[12:10] and the clock select reads 0.
- R4: For any other captured boot device code, the bypass flag is 0, the clock select is strap[12:10] and the extended configuration reads 0.
- R5: Full, soft/hard and local resets leave the captured status unchanged, even when the strap pins have changed.
- R6: A power-on or full reset released with the hibernation flag low raises the boot-start output for exactly one cycle. That cycle is the one after the first clock edge at which all requests are low. Nothing pulses while a request is held.
- R7: A soft/hard reset release gives the boot-start pulse whatever the hibernation flag says.
- R8: A local reset release gives a single-cycle core-reset pulse and no boot-start pulse.
- R9: A power-on or full reset released with the hibernation flag high gives a single-cycle resume request with no boot-start pulse, and the resume address output equals the hibernation address.
- R10: When several requests overlap within one reset window, or arrive at different times within it, the strongest kind seen decides the action. The order from strongest to weakest is power-on, full, soft/hard, local.
- R11: At most one of boot-start, resume request and core-reset is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset request, level; also the synchronous reset of the status register |
| full_req | input | 1 | Full reset request, level |
| soft_req | input | 1 | Soft/hard reset request, level |
| local_req | input | 1 | Core-local reset request, level |
| strap_pins | input | 13 | Boot-strap pin bus |
| hib_flag | input | 1 | Hibernation indicated by the power-state register |
| hib_addr | input | 32 | Branch address held in the power-state register |
| boot_dev | output | 3 | Captured boot device code |
| dev_cfg | output | 7 | Captured device-specific configuration |
| pll_sel | output | 3 | Clock select, zero when bypassed |
| ext_cfg | output | 3 | Extended configuration, nonzero only when bypassed |
| pll_bypass | output | 1 | Clock generator bypass flag |
| boot_start | output | 1 | Single-cycle boot sequencer start |
| resume_req | output | 1 | Single-cycle resume-from-hibernation request |
| resume_addr | output | 32 | Branch address for the resume request |
| core_rst_pulse | output | 1 | Single-cycle core-only reset |

## Verification
The bench changes the strap pins before full, soft and local resets. A design that captured straps on every reset would show new fields. It holds the hibernation flag high during soft resets, where a design that checked it there would resume instead of booting. It drives boot codes 5 and 6 next to their neighbours 4 and 7, so a wrong bypass decode shows up as a swapped clock select and extended field. It also raises a weak request first and a strong one later in the same window. A dispatcher that decides on the first request, or on the last one to drop, would issue the wrong pulse.

// File: rtl/strap_pkg.sv
package strap_pkg;
  // Numeric order encodes priority: larger value wins
  typedef enum logic [2:0] {
    RK_NONE  = 3'd0,
    RK_LOCAL = 3'd1,
    RK_SOFT  = 3'd2,
    RK_FULL  = 3'd3,
    RK_POR   = 3'd4
  } rst_kind_e;
endpackage

// File: rtl/rst_arbiter.sv
module rst_arbiter
  import strap_pkg::*;
(
  input  logic      clk,
  input  logic      por_req,
  input  logic      full_req,
  input  logic      soft_req,
  input  logic      local_req,
  output logic      release_p,
  output rst_kind_e rel_kind
);
  rst_kind_e req_kind;
  rst_kind_e kind_q;
  logic      active_q;

  always_comb begin
    if (por_req)        req_kind = RK_POR;
    else if (full_req)  req_kind = RK_FULL;
    else if (soft_req)  req_kind = RK_SOFT;
    else if (local_req) req_kind = RK_LOCAL;
    else                req_kind = RK_NONE;
  end

  // Remember the strongest request of the current window
  always_ff @(posedge clk) begin
    if (por_req) begin
      active_q <= 1'b1;
      kind_q   <= RK_POR;
    end else if (req_kind != RK_NONE) begin
      active_q <= 1'b1;
      if (!active_q || (req_kind > kind_q)) kind_q <= req_kind;
    end else begin
      active_q <= 1'b0;
    end
  end

  assign release_p = active_q && (req_kind == RK_NONE);
  assign rel_kind  = kind_q;
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int DEV_W = 3,
  parameter int CFG_W = 7,
  parameter int PLL_W = 3,
  parameter int NUM_BYP = 2,
  parameter logic [NUM_BYP*DEV_W-1:0] BYP_CODES = {3'd6, 3'd5},
  localparam int STRAP_W = DEV_W + CFG_W + PLL_W
) (
  input  logic               clk,
  input  logic               por_req,
  input  logic               capture,
  input  logic [STRAP_W-1:0] strap,
  output logic [DEV_W-1:0]   boot_dev,
  output logic [CFG_W-1:0]   dev_cfg,
  output logic [PLL_W-1:0]   pll_sel,
  output logic [PLL_W-1:0]   ext_cfg,
  output logic               pll_bypass
);
  localparam int CFG_LO = DEV_W;
  localparam int PLL_LO = DEV_W + CFG_W;

  logic [DEV_W-1:0] dev_in;
  logic [PLL_W-1:0] top_in;
  logic [NUM_BYP-1:0] byp_hit;
  logic byp_in;

  assign dev_in = strap[DEV_W-1:0];
  assign top_in = strap[PLL_LO +: PLL_W];

  for (genvar i = 0; i < NUM_BYP; i++) begin : g_byp
    assign byp_hit[i] = (dev_in == BYP_CODES[i*DEV_W +: DEV_W]);
  end
  assign byp_in = |byp_hit;

  always_ff @(posedge clk) begin
    if (por_req) begin
      boot_dev   <= '0;
      dev_cfg    <= '0;
      pll_sel    <= '0;
      ext_cfg    <= '0;
      pll_bypass <= 1'b0;
    end else if (capture) begin
      boot_dev   <= dev_in;
      dev_cfg    <= strap[CFG_LO +: CFG_W];
      pll_bypass <= byp_in;
      pll_sel    <= byp_in ? '0 : top_in;
      ext_cfg    <= byp_in ? top_in : '0;
    end
  end
endmodule

// File: rtl/boot_dispatch.sv
module boot_dispatch
  import strap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              release_p,
  input  rst_kind_e         rel_kind,
  input  logic              hib_flag,
  input  logic [ADDR_W-1:0] hib_addr,
  output logic              boot_start,
  output logic              resume_req,
  output logic [ADDR_W-1:0] resume_addr,
  output logic              core_rst_pulse
);
  always_ff @(posedge clk) begin
    if (por_req) begin
      boot_start     <= 1'b0;
      resume_req     <= 1'b0;
      core_rst_pulse <= 1'b0;
      resume_addr    <= '0;
    end else begin
      boot_start     <= 1'b0;
      resume_req     <= 1'b0;
      core_rst_pulse <= 1'b0;
      if (release_p) begin
        unique case (rel_kind)
          RK_POR, RK_FULL: begin
            if (hib_flag) begin
              resume_req  <= 1'b1;
              resume_addr <= hib_addr;
            end else begin
              boot_start <= 1'b1;
            end
          end
          RK_SOFT:  boot_start     <= 1'b1;
          RK_LOCAL: core_rst_pulse <= 1'b1;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/strap_reset_dispatch.sv
module strap_reset_dispatch
  import strap_pkg::*;
#(
  parameter int DEV_W  = 3,
  parameter int CFG_W  = 7,
  parameter int PLL_W  = 3,
  parameter int ADDR_W = 32,
  localparam int STRAP_W = DEV_W + CFG_W + PLL_W
) (
  input  logic               clk,
  input  logic               por_req,
  input  logic               full_req,
  input  logic               soft_req,
  input  logic               local_req,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               hib_flag,
  input  logic [ADDR_W-1:0]  hib_addr,
  output logic [DEV_W-1:0]   boot_dev,
  output logic [CFG_W-1:0]   dev_cfg,
  output logic [PLL_W-1:0]   pll_sel,
  output logic [PLL_W-1:0]   ext_cfg,
  output logic               pll_bypass,
  output logic               boot_start,
  output logic               resume_req,
  output logic [ADDR_W-1:0]  resume_addr,
  output logic               core_rst_pulse
);
  logic      release_p;
  rst_kind_e rel_kind;
  logic      capture;

  rst_arbiter u_arb (
    .clk(clk), .por_req(por_req), .full_req(full_req),
    .soft_req(soft_req), .local_req(local_req),
    .release_p(release_p), .rel_kind(rel_kind)
  );

  assign capture = release_p && (rel_kind == RK_POR);

  strap_latch #(.DEV_W(DEV_W), .CFG_W(CFG_W), .PLL_W(PLL_W)) u_latch (
    .clk(clk), .por_req(por_req), .capture(capture), .strap(strap_pins),
    .boot_dev(boot_dev), .dev_cfg(dev_cfg), .pll_sel(pll_sel),
    .ext_cfg(ext_cfg), .pll_bypass(pll_bypass)
  );

  boot_dispatch #(.ADDR_W(ADDR_W)) u_disp (
    .clk(clk), .por_req(por_req), .release_p(release_p), .rel_kind(rel_kind),
    .hib_flag(hib_flag), .hib_addr(hib_addr),
    .boot_start(boot_start), .resume_req(resume_req),
    .resume_addr(resume_addr), .core_rst_pulse(core_rst_pulse)
  );
endmodule

// File: rtl/strap_reset_dispatch_chk.sv
module strap_reset_dispatch_chk #(
  parameter int DEV_W  = 3,
  parameter int CFG_W  = 7,
  parameter int PLL_W  = 3,
  parameter int ADDR_W = 32,
  localparam int STRAP_W = DEV_W + CFG_W + PLL_W
) (
  input logic               clk,
  input logic               por_req,
  input logic               full_req,
  input logic               soft_req,
  input logic               local_req,
  input logic [STRAP_W-1:0] strap_pins,
  input logic               hib_flag,
  input logic [ADDR_W-1:0]  hib_addr,
  input logic [DEV_W-1:0]   boot_dev,
  input logic [CFG_W-1:0]   dev_cfg,
  input logic [PLL_W-1:0]   pll_sel,
  input logic [PLL_W-1:0]   ext_cfg,
  input logic               pll_bypass,
  input logic               boot_start,
  input logic               resume_req,
  input logic [ADDR_W-1:0]  resume_addr,
  input logic               core_rst_pulse
);
  logic por_seen = 1'b0;
  always_ff @(posedge clk) por_seen <= por_req;

  // R1: state cleared one edge into a power-on request
  always @(negedge clk) begin
    if (por_seen) begin
      assert_por_clear_R1: assert (boot_dev == '0 && dev_cfg == '0 && !pll_bypass
        && !boot_start && !resume_req && !core_rst_pulse)
        else $error("R1 state not cleared under power-on");
    end
  end

  assert_status_hold_R5: assert property (@(posedge clk) disable iff (por_req)
    !$stable({boot_dev, dev_cfg, pll_sel, ext_cfg, pll_bypass}) |-> $past(por_req, 2));

  assert_boot_single_R6: assert property (@(posedge clk) disable iff (por_req)
    boot_start |=> !boot_start);

  assert_boot_after_release_R6: assert property (@(posedge clk) disable iff (por_req)
    boot_start |-> $past(!(full_req || soft_req || local_req)));

  assert_core_single_R8: assert property (@(posedge clk) disable iff (por_req)
    core_rst_pulse |=> !core_rst_pulse);

  assert_resume_single_R9: assert property (@(posedge clk) disable iff (por_req)
    resume_req |=> !resume_req);

  assert_bypass_decode_R3: assert property (@(posedge clk) disable iff (por_req)
    pll_bypass |-> (pll_sel == '0));

  assert_one_action_R11: assert property (@(posedge clk) disable iff (por_req)
    $countones({boot_start, resume_req, core_rst_pulse}) <= 1);
endmodule

bind strap_reset_dispatch strap_reset_dispatch_chk #(
  .DEV_W(DEV_W), .CFG_W(CFG_W), .PLL_W(PLL_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/strap_reset_dispatch_test.sv
module strap_reset_dispatch_test;
  logic clk = 1'b0;
  logic por_req = 1'b1, full_req = 1'b0, soft_req = 1'b0, local_req = 1'b0;
  logic [12:0] strap_pins = '0;
  logic hib_flag = 1'b0;
  logic [31:0] hib_addr = '0;
  logic [2:0] boot_dev, pll_sel, ext_cfg;
  logic [6:0] dev_cfg;
  logic pll_bypass, boot_start, resume_req, core_rst_pulse;
  logic [31:0] resume_addr;

  int checks = 0;
  int errors = 0;

  logic [2:0] e_dev = '0, e_sel = '0, e_ext = '0;
  logic [6:0] e_cfg = '0;
  logic e_byp = 1'b0;

  always #5 clk = ~clk;

  strap_reset_dispatch uut (
    .clk(clk), .por_req(por_req), .full_req(full_req), .soft_req(soft_req),
    .local_req(local_req), .strap_pins(strap_pins), .hib_flag(hib_flag),
    .hib_addr(hib_addr), .boot_dev(boot_dev), .dev_cfg(dev_cfg),
    .pll_sel(pll_sel), .ext_cfg(ext_cfg), .pll_bypass(pll_bypass),
    .boot_start(boot_start), .resume_req(resume_req),
    .resume_addr(resume_addr), .core_rst_pulse(core_rst_pulse)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit3 power-on, bit2 full, bit1 soft, bit0 local
  task automatic drive(input logic [3:0] r);
    por_req = r[3]; full_req = r[2]; soft_req = r[1]; local_req = r[0];
  endtask

  function automatic int strongest(input logic [3:0] r);
    if (r[3]) return 4;
    if (r[2]) return 3;
    if (r[1]) return 2;
    if (r[0]) return 1;
    return 0;
  endfunction

  task automatic check_fields(input string tag);
    chk(boot_dev, e_dev, {tag, " boot_dev"});
    chk(dev_cfg, e_cfg, {tag, " dev_cfg"});
    chk(pll_sel, e_sel, {tag, " pll_sel"});
    chk(ext_cfg, e_ext, {tag, " ext_cfg"});
    chk(pll_bypass, e_byp, {tag, " pll_bypass"});
  endtask

  task automatic run_reset(input logic [3:0] ph1, input logic [3:0] ph2,
                           input logic [12:0] straps, input logic hf,
                           input logic [31:0] ha);
    logic [3:0] all;
    int k;
    logic eb, er, ec;
    all = ph1 | ph2;
    k = strongest(all);
    strap_pins = straps; hib_flag = hf; hib_addr = ha;
    @(negedge clk) drive(ph1);
    repeat (2) @(negedge clk);
    drive(all);
    repeat (2) @(negedge clk);
    if (all[3]) begin
      chk(boot_dev, 0, "R1 boot_dev under power-on");
      chk(dev_cfg, 0, "R1 dev_cfg under power-on");
      chk(pll_bypass, 0, "R1 bypass under power-on");
    end
    chk({boot_start, resume_req, core_rst_pulse}, 0, "R6 no pulse while held");
    drive(4'b0000);
    if (k == 4) begin
      e_dev = straps[2:0];
      e_cfg = straps[9:3];
      e_byp = (straps[2:0] == 3'd5) || (straps[2:0] == 3'd6);
      e_sel = e_byp ? 3'd0 : straps[12:10];
      e_ext = e_byp ? straps[12:10] : 3'd0;
    end
    eb = ((k == 4 || k == 3) && !hf) || (k == 2);
    er = (k == 4 || k == 3) && hf;
    ec = (k == 1);
    @(negedge clk);
    chk(boot_start, eb, "R6 R7 R10 boot_start on release");
    chk(resume_req, er, "R9 R10 resume_req on release");
    chk(core_rst_pulse, ec, "R8 R10 core_rst_pulse on release");
    if (er) chk(resume_addr, ha, "R9 resume_addr");
    check_fields(k == 4 ? "R2 R3 R4 capture" : "R5 status held");
    @(negedge clk);
    chk({boot_start, resume_req, core_rst_pulse}, 0, "R6 R8 R9 single cycle");
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (2) @(negedge clk);
    chk({boot_start, resume_req, core_rst_pulse}, 0, "R1 pulses at start");
    chk(boot_dev, 0, "R1 boot_dev at start");
    drive(4'b0000);
    @(negedge clk);
    // directed: R4 clock select path
    run_reset(4'b1000, 4'b0000, {3'd5, 7'h55, 3'd3}, 1'b0, 32'h0);
    run_reset(4'b1000, 4'b0000, {3'd2, 7'h2A, 3'd7}, 1'b0, 32'h0);
    run_reset(4'b1000, 4'b0000, {3'd6, 7'h11, 3'd4}, 1'b0, 32'h0);
    // R3 bypass codes
    run_reset(4'b1000, 4'b0000, {3'd3, 7'h7F, 3'd5}, 1'b0, 32'h0);
    run_reset(4'b1000, 4'b0000, {3'd1, 7'h01, 3'd6}, 1'b0, 32'h0);
    // R5 other resets with new straps
    run_reset(4'b0100, 4'b0000, 13'h1FFF, 1'b0, 32'h0);
    run_reset(4'b0001, 4'b0000, 13'h0AAA, 1'b0, 32'h0);
    // R7 soft ignores hibernation
    run_reset(4'b0010, 4'b0000, 13'h0123, 1'b1, 32'hDEAD_BEEF);
    // R9 hibernation after full and power-on
    run_reset(4'b0100, 4'b0000, 13'h0456, 1'b1, 32'h8000_1000);
    run_reset(4'b1000, 4'b0000, 13'h0007, 1'b1, 32'h0C00_0040);
    // R10 late stronger request decides
    run_reset(4'b0001, 4'b0010, 13'h0, 1'b0, 32'h0);
    run_reset(4'b0010, 4'b0100, 13'h0, 1'b1, 32'h1234_5678);
    run_reset(4'b0001, 4'b1000, 13'h1C0E, 1'b0, 32'h0);
    run_reset(4'b0111, 4'b0000, 13'h0, 1'b0, 32'h0);
    for (int i = 0; i < 60; i++) begin
      logic [3:0] a, b;
      a = 4'($urandom_range(1, 15));
      b = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) begin
        a[3] = 1'b0; b[3] = 1'b0;
        if (a == 4'b0) a = 4'b0001;
      end
      run_reset(a, b, 13'($urandom), 1'($urandom), $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule